// File: doc/BRIEF.md
# Debug Lane Select and Align

This block sits between a source block's debug output and a trace recorder. The source presents one debug line made of four lanes, each with a data word, a valid bit and a frame bit. The block realigns that line for the recorder. It shifts the line right by whole lanes, blanks lanes that are switched off and forces valid or frame flags on chosen lanes. It also tags every output lane with a 3-bit hardware ID. A line-width mode selects 32-bit or 64-bit lanes.

A 16-bit control word sets the per-lane behaviour. The control word, the width mode, the ID word and the unify option are taken in when recording starts. They stay frozen until the next start, whatever the inputs do in between. While recording is stopped the outputs stay quiet. While recording runs, every output is registered, one cycle after its input.

Top module: `dbg_lane_align`

## Requirements
- R1: The control word fields are: bits 3:0 lane enable mask, bits 7:4 right-shift count, bits 11:8 forced-valid mask, bits 15:12 forced-frame mask. Bit i of each mask refers to lane i.
- R2: While recording, an output lane whose enable bit is 0 has zero data. Its valid bit and frame bit are 0 unless the matching forced bit is set.
- R3: With shift count s below 4, output lane i carries the data, valid and frame of input lane i+s. When i+s is 4 or more, output lane i has zero data, valid 0 and frame 0. A count from 4 to 15 empties every lane. The shift is applied before the enable mask.
- R4: A set bit i in the forced-valid mask makes output valid bit i 1, regardless of the input valid, the enable mask and the shift.
- R5: A set bit i in the forced-frame mask makes output frame bit i 1, regardless of the input frame, the enable mask and the shift.
- R6: Lanes occupy 64 bits each in the data ports, with lane i at bits 64*i+63:64*i. When the wide flag is 0, only the low 32 bits of each lane are carried and the upper 32 bits of each output lane are 0. When the wide flag is 1, all 64 bits are carried.
- R7: The output ID word equals the captured ID word, where bits 3*i+2:3*i belong to lane i. When unify is 1, the output ID word is 0.
- R8: The outputs are registered with one cycle of latency. Lane inputs present before a rising edge appear on the outputs after that edge. The edge that starts recording still produces quiet outputs.
- R9: While recording is stopped, and out of reset, all data, valid, frame and ID outputs are 0.
- R10: The control word, wide flag, unify and ID word are captured on the edge where rec_start_i is 1. They do not change while recording, even if the inputs change. rec_start_i takes priority over rec_stop_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rec_start_i | input | 1 | Start recording, capture configuration |
| rec_stop_i | input | 1 | Stop recording |
| cfg_word_i | input | 16 | Per-lane control word |
| wide_i | input | 1 | 1 = 64-bit lanes, 0 = 32-bit lanes |
| unify_i | input | 1 | Force all lane IDs to 0 |
| hw_ids_i | input | 12 | Per-lane 3-bit hardware IDs |
| lane_data_i | input | 256 | Four input lanes, lane i at bits 64*i+63:64*i |
| lane_valid_i | input | 4 | Per-lane input valid |
| lane_frame_i | input | 4 | Per-lane input frame |
| out_data_o | output | 256 | Realigned output lanes |
| out_valid_o | output | 4 | Per-lane output valid |
| out_frame_o | output | 4 | Per-lane output frame |
| out_ids_o | output | 12 | Per-lane output hardware IDs |

## Verification
The hardest case to reach from the ports is a configuration change in the middle of a recording. The inputs must move while the outputs must not, and the only sign of a fault is output that should have stayed fixed. The stimulus handles this by inverting every configuration input after a recorded result has been checked, then checking the same result again one cycle later. The bench sweeps the shift counts (including counts of 4 and above) against every enable and forced-valid mask. Across that sweep the width mode, unify, input flags and IDs vary, so that shifted-in empty lanes meet forced flags.

// File: rtl/dla_pkg.sv
package dla_pkg;
    localparam int LANES   = 4;
    localparam int FIELD_W = 4;
    localparam int CFG_W   = 4 * FIELD_W;
    localparam int ID_W    = 3;
    localparam int IDS_W   = LANES * ID_W;
    localparam int SEL_W   = $clog2(LANES);

    typedef struct packed {
        logic [FIELD_W-1:0] force_frame;
        logic [FIELD_W-1:0] force_valid;
        logic [FIELD_W-1:0] shift;
        logic [FIELD_W-1:0] enable;
    } lane_cfg_t;

    typedef struct packed {
        lane_cfg_t        word;
        logic [IDS_W-1:0] ids;
        logic             unify;
        logic             wide;
    } ctl_t;

    function automatic logic shift_in_range(input logic [FIELD_W-1:0] sh);
        return int'(sh) < LANES;
    endfunction
endpackage

// File: rtl/dla_ctl.sv
module dla_ctl
    import dla_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic stop_i,
    input  ctl_t ctl_i,
    output logic active_o,
    output ctl_t ctl_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            active_o <= 1'b0;
            ctl_o    <= '0;
        end else if (start_i) begin
            active_o <= 1'b1;
            ctl_o    <= ctl_i;
        end else if (stop_i) begin
            active_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dla_shift.sv
module dla_shift
    import dla_pkg::*;
#(
    parameter int LANE_W = 64
) (
    input  logic [FIELD_W-1:0] shift_i,
    input  logic [LANE_W-1:0]  data_i  [LANES],
    input  logic [LANES-1:0]   valid_i,
    input  logic [LANES-1:0]   frame_i,
    output logic [LANE_W-1:0]  data_o  [LANES],
    output logic [LANES-1:0]   valid_o,
    output logic [LANES-1:0]   frame_o
);
    logic [SEL_W-1:0] sel;
    logic             in_range;

    assign sel      = shift_i[SEL_W-1:0];
    assign in_range = shift_in_range(shift_i);

    for (genvar i = 0; i < LANES; i++) begin : g_out
        logic [LANE_W-1:0] cand_d [LANES];
        logic [LANES-1:0]  cand_v;
        logic [LANES-1:0]  cand_f;

        for (genvar k = 0; k < LANES; k++) begin : g_cand
            if (i + k < LANES) begin : g_src
                assign cand_d[k] = data_i[i+k];
                assign cand_v[k] = valid_i[i+k];
                assign cand_f[k] = frame_i[i+k];
            end else begin : g_empty
                assign cand_d[k] = '0;
                assign cand_v[k] = 1'b0;
                assign cand_f[k] = 1'b0;
            end
        end

        assign data_o[i]  = in_range ? cand_d[sel] : '0;
        assign valid_o[i] = in_range & cand_v[sel];
        assign frame_o[i] = in_range & cand_f[sel];
    end
endmodule

// File: rtl/dla_mask.sv
module dla_mask
    import dla_pkg::*;
#(
    parameter int LANE_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [FIELD_W-1:0] enable_i,
    input  logic [FIELD_W-1:0] force_valid_i,
    input  logic [FIELD_W-1:0] force_frame_i,
    input  logic               wide_i,
    input  logic [LANE_W-1:0]  data_i  [LANES],
    input  logic [LANES-1:0]   valid_i,
    input  logic [LANES-1:0]   frame_i,
    output logic [LANE_W-1:0]  data_o  [LANES],
    output logic [LANES-1:0]   valid_o,
    output logic [LANES-1:0]   frame_o
);
    localparam int UPPER_W = LANE_W - NARROW_W;

    logic [LANE_W-1:0] width_mask;
    assign width_mask = {{UPPER_W{wide_i}}, {NARROW_W{1'b1}}};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data_o[i]  = enable_i[i] ? (data_i[i] & width_mask) : '0;
        assign valid_o[i] = (enable_i[i] & valid_i[i]) | force_valid_i[i];
        assign frame_o[i] = (enable_i[i] & frame_i[i]) | force_frame_i[i];
    end
endmodule

// File: rtl/dbg_lane_align.sv
module dbg_lane_align
    import dla_pkg::*;
#(
    parameter int LANE_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    rec_start_i,
    input  logic                    rec_stop_i,
    input  logic [CFG_W-1:0]        cfg_word_i,
    input  logic                    wide_i,
    input  logic                    unify_i,
    input  logic [IDS_W-1:0]        hw_ids_i,
    input  logic [LANES*LANE_W-1:0] lane_data_i,
    input  logic [LANES-1:0]        lane_valid_i,
    input  logic [LANES-1:0]        lane_frame_i,
    output logic [LANES*LANE_W-1:0] out_data_o,
    output logic [LANES-1:0]        out_valid_o,
    output logic [LANES-1:0]        out_frame_o,
    output logic [IDS_W-1:0]        out_ids_o
);
    ctl_t ctl_in;
    ctl_t ctl_q;
    logic active;

    assign ctl_in.word  = lane_cfg_t'(cfg_word_i);
    assign ctl_in.ids   = hw_ids_i;
    assign ctl_in.unify = unify_i;
    assign ctl_in.wide  = wide_i;

    dla_ctl u_ctl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (rec_start_i),
        .stop_i   (rec_stop_i),
        .ctl_i    (ctl_in),
        .active_o (active),
        .ctl_o    (ctl_q)
    );

    logic [LANE_W-1:0] in_d [LANES];
    logic [LANE_W-1:0] sh_d [LANES];
    logic [LANE_W-1:0] mk_d [LANES];
    logic [LANES-1:0]  sh_v, sh_f, mk_v, mk_f;

    for (genvar i = 0; i < LANES; i++) begin : g_unpack
        assign in_d[i] = lane_data_i[i*LANE_W +: LANE_W];
    end

    dla_shift #(.LANE_W(LANE_W)) u_shift (
        .shift_i (ctl_q.word.shift),
        .data_i  (in_d),
        .valid_i (lane_valid_i),
        .frame_i (lane_frame_i),
        .data_o  (sh_d),
        .valid_o (sh_v),
        .frame_o (sh_f)
    );

    dla_mask #(.LANE_W(LANE_W), .NARROW_W(NARROW_W)) u_mask (
        .enable_i      (ctl_q.word.enable),
        .force_valid_i (ctl_q.word.force_valid),
        .force_frame_i (ctl_q.word.force_frame),
        .wide_i        (ctl_q.wide),
        .data_i        (sh_d),
        .valid_i       (sh_v),
        .frame_i       (sh_f),
        .data_o        (mk_d),
        .valid_o       (mk_v),
        .frame_o       (mk_f)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_data_o  <= '0;
            out_valid_o <= '0;
            out_frame_o <= '0;
            out_ids_o   <= '0;
        end else begin
            for (int i = 0; i < LANES; i++) begin
                out_data_o[i*LANE_W +: LANE_W] <= active ? mk_d[i] : '0;
            end
            out_valid_o <= active ? mk_v : '0;
            out_frame_o <= active ? mk_f : '0;
            out_ids_o   <= (active && !ctl_q.unify) ? ctl_q.ids : '0;
        end
    end
endmodule

// File: rtl/dla_checker.sv
module dla_checker
    import dla_pkg::*;
#(
    parameter int LANE_W   = 64,
    parameter int NARROW_W = 32
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    active,
    input logic [$bits(ctl_t)-1:0] ctl_bits,
    input logic [FIELD_W-1:0]      en,
    input logic [FIELD_W-1:0]      fv,
    input logic [FIELD_W-1:0]      ff,
    input logic                    unify,
    input logic                    wide,
    input logic [LANES*LANE_W-1:0] out_data,
    input logic [LANES-1:0]        out_valid,
    input logic [LANES-1:0]        out_frame,
    input logic [IDS_W-1:0]        out_ids
);
    logic [LANES-1:0] upper_any;
    for (genvar i = 0; i < LANES; i++) begin : g_up
        assign upper_any[i] = |out_data[i*LANE_W+NARROW_W +: LANE_W-NARROW_W];
    end

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> (out_valid == '0 && out_frame == '0 && out_ids == '0));

    a_r4_forced_valid: assert property (@(posedge clk) disable iff (rst)
        $past(active) |-> ((out_valid & $past(fv)) == $past(fv)));

    a_r5_forced_frame: assert property (@(posedge clk) disable iff (rst)
        $past(active) |-> ((out_frame & $past(ff)) == $past(ff)));

    a_r2_disabled_lane: assert property (@(posedge clk) disable iff (rst)
        $past(active) |-> ((out_valid & ~($past(en) | $past(fv))) == '0));

    a_r7_unify_zero: assert property (@(posedge clk) disable iff (rst)
        $past(active && unify) |-> (out_ids == '0));

    a_r6_narrow_upper: assert property (@(posedge clk) disable iff (rst)
        $past(active && !wide) |-> (upper_any == '0));

    a_r10_frozen_cfg: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(ctl_bits));
endmodule

bind dbg_lane_align dla_checker #(.LANE_W(LANE_W), .NARROW_W(NARROW_W)) u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .start     (rec_start_i),
    .active    (active),
    .ctl_bits  (ctl_q),
    .en        (ctl_q.word.enable),
    .fv        (ctl_q.word.force_valid),
    .ff        (ctl_q.word.force_frame),
    .unify     (ctl_q.unify),
    .wide      (ctl_q.wide),
    .out_data  (out_data_o),
    .out_valid (out_valid_o),
    .out_frame (out_frame_o),
    .out_ids   (out_ids_o)
);

// File: tb/sim_dbg_lane_align.sv
module sim_dbg_lane_align;
    logic         clk = 1'b0;
    logic         rst;
    logic         rec_start, rec_stop;
    logic [15:0]  cfg_word;
    logic         wide, unify;
    logic [11:0]  hw_ids;
    logic [255:0] lane_data;
    logic [3:0]   lane_valid, lane_frame;
    logic [255:0] out_data;
    logic [3:0]   out_valid, out_frame;
    logic [11:0]  out_ids;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [255:0] exp_d;
    logic [3:0]   exp_v, exp_f;
    logic [11:0]  exp_id;

    always #4 clk = ~clk;

    dbg_lane_align u0 (
        .clk_i(clk), .rst_i(rst), .rec_start_i(rec_start), .rec_stop_i(rec_stop),
        .cfg_word_i(cfg_word), .wide_i(wide), .unify_i(unify), .hw_ids_i(hw_ids),
        .lane_data_i(lane_data), .lane_valid_i(lane_valid), .lane_frame_i(lane_frame),
        .out_data_o(out_data), .out_valid_o(out_valid), .out_frame_o(out_frame),
        .out_ids_o(out_ids)
    );

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic compute_expected();
        int s;
        s = int'(cfg_word[7:4]);
        for (int i = 0; i < 4; i++) begin
            logic [63:0] sd;
            logic sv, sf;
            sd = '0; sv = 1'b0; sf = 1'b0;
            if (s < 4 && i + s < 4) begin
                sd = lane_data[(i+s)*64 +: 64];
                sv = lane_valid[i+s];
                sf = lane_frame[i+s];
            end
            if (!cfg_word[i]) begin
                sd = '0; sv = 1'b0; sf = 1'b0;
            end
            if (!wide) sd[63:32] = '0;
            exp_d[i*64 +: 64] = sd;
            exp_v[i] = sv | cfg_word[8+i];
            exp_f[i] = sf | cfg_word[12+i];
        end
        exp_id = unify ? 12'h000 : hw_ids;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 R6 data"}, out_data, exp_d);
        chk({tag, " R2 R4 valid"}, {252'd0, out_valid}, {252'd0, exp_v});
        chk({tag, " R2 R5 frame"}, {252'd0, out_frame}, {252'd0, exp_f});
        chk({tag, " R7 ids"}, {244'd0, out_ids}, {244'd0, exp_id});
    endtask

    task automatic check_quiet(input string tag);
        chk({tag, " R9 quiet data"}, out_data, '0);
        chk({tag, " R9 quiet flags"}, {244'd0, out_ids, out_valid, out_frame}, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int idx;
        rst = 1'b1; rec_start = 1'b0; rec_stop = 1'b0;
        cfg_word = '0; wide = 1'b0; unify = 1'b0; hw_ids = '0;
        lane_data = '0; lane_valid = '0; lane_frame = '0;
        repeat (3) @(negedge clk);
        check_quiet("reset");
        rst = 1'b0;
        idx = 0;
        for (int sh = 0; sh < 6; sh++) begin
            for (int en = 0; en < 16; en++) begin
                for (int fv = 0; fv < 16; fv++) begin
                    logic [3:0] s_val;
                    logic [15:0] saved_cfg;
                    s_val = (sh == 5) ? 4'(9 + en % 7) : 4'(sh);
                    // R1: enable 3:0, shift 7:4, forced valid 11:8, forced frame 15:12
                    cfg_word = {4'((en * 3 + sh + fv) & 15), 4'(fv), s_val, 4'(en)};
                    wide  = idx[0] ^ idx[5];
                    unify = (idx % 7 == 0);
                    hw_ids = 12'((idx * 37 + 5) & 12'hFFF);
                    for (int k = 0; k < 4; k++) begin
                        lane_data[k*64 +: 64] = {32'hA5000000 | 32'(idx << 4) | 32'(k),
                                                 32'h3C000000 + 32'(idx * 5 + k)};
                    end
                    lane_valid = 4'(idx) ^ 4'hA;
                    lane_frame = ~4'(idx >> 4);
                    compute_expected();
                    rec_start = 1'b1;
                    @(negedge clk);
                    rec_start = 1'b0;
                    if (idx % 32 == 0) check_quiet("R8 start edge");
                    @(negedge clk);
                    check_all("R1 R8 record");
                    if (idx % 16 == 3) begin
                        saved_cfg = cfg_word;
                        cfg_word = ~saved_cfg;
                        wide = ~wide;
                        unify = ~unify;
                        hw_ids = ~hw_ids;
                        @(negedge clk);
                        check_all("R10 frozen");
                    end
                    rec_stop = 1'b1;
                    @(negedge clk);
                    rec_stop = 1'b0;
                    @(negedge clk);
                    check_quiet("stopped");
                    idx++;
                end
            end
        end
        // R10: start wins over stop
        cfg_word = 16'h0F0F; wide = 1'b1; unify = 1'b0; hw_ids = 12'hABC;
        lane_valid = 4'h0; lane_frame = 4'h0;
        compute_expected();
        rec_start = 1'b1; rec_stop = 1'b1;
        @(negedge clk);
        rec_start = 1'b0; rec_stop = 1'b0;
        @(negedge clk);
        check_all("R10 start priority");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule